// File: doc/BRIEF.md
# Serial Coded-Stream Output Port

This block hands encoded bytes to an external consumer. The consumer supplies the port clock and a read enable that is active low. Bytes come in from the encoder side through a valid/ready write port. They wait in a small synchronous queue. The block then presents them on an output data bus, one item per clock. In byte mode an item is a whole byte. In bit mode an item is a single bit, and each byte is sent MSB first over eight clocks. Both modes follow the same cycle timing.

The block flags that data is waiting with an active-high `nonempty` output. When the consumer holds `rd_en_n` low while `nonempty` is high, a new item appears after each rising edge, with no gap between items. `nonempty` falls on the same edge that presents the last item. The data pins are then driven for one extra cycle with contents that carry no meaning, after which they are released. If the consumer raises `rd_en_n` in the middle of a stream, the pins hold their value and no item is lost.

On the write side, a byte is accepted on an edge where `in_valid` and `in_ready` are both high. `in_ready` drops only while the queue is full, and `in_valid` may stay high through that time without loss. `bit_mode` is a static setting and changes only while the port is idle, meaning `nonempty` and `dout_oe` are both low.

Top module: `coded_serial_port`

## Requirements
- R1: After reset, `nonempty` and `dout_oe` are 0, `dout` is all zeros and `in_ready` is 1.
- R2: `in_ready` is 0 exactly while the queue holds DEPTH bytes. Offered data is not taken in that state and is taken once space frees up.
- R3: After an edge that accepts a byte into an empty port, `nonempty` reads 1.
- R4: In byte mode, when `rd_en_n` is sampled low at an edge while `nonempty` is 1, the oldest byte appears on `dout` after that edge and `dout_oe` is 1.
- R5: While `rd_en_n` stays low and data remains, each consecutive edge presents the next item, with no idle cycle between items.
- R6: In bit mode (`bit_mode`=1), each byte is presented on `dout[0]` MSB first over eight consecutive items, and `dout[7:1]` are 0.
- R7: `nonempty` goes to 0 on the same edge that presents the last remaining item.
- R8: After the last item, `dout_oe` stays 1 for exactly one further cycle. It then goes to 0 and `dout` returns to all zeros.
- R9: An edge with `rd_en_n` high changes neither `dout` nor `dout_oe` while items remain, and the stream resumes with the next unsent item.
- R10: Bytes leave in the order they were accepted. In bit mode, the first bit of the next byte directly follows the last bit of the previous one.
- R11: `rd_en_n` held low while `nonempty` is 0 presents nothing and consumes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock supplied by the consumer |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_mode | input | 1 | 1 selects bit mode, 0 selects byte mode |
| in_valid | input | 1 | Write side: byte offered |
| in_ready | output | 1 | Write side: queue can take a byte |
| in_data | input | 8 | Write side: byte to be sent |
| rd_en_n | input | 1 | Consumer read enable, active low |
| nonempty | output | 1 | High while at least one item remains to be sent |
| dout | output | 8 | Output data: a byte, or the current bit on bit 0 |
| dout_oe | output | 1 | High while the data pins are driven |

## Verification
The stream is tested with four read-enable patterns:
- Continuous reading in both modes shows that items arrive with no gaps. It also pins down the edge on which `nonempty` falls and the length of the one-cycle tail.
- A duty-cycled read enable over a full queue, and a pause in the middle of a byte in bit mode, separate holding from skipping or repeating an item.
- Holding the read enable low over an empty port confirms that nothing is presented.
- Writing while a stream is in progress shows that bytes arriving late still join the stream in order.

Filling the queue while `in_valid` stays high probes the back-pressure limit.

// File: rtl/coded_serial_pkg.sv
package coded_serial_pkg;
  typedef enum logic {
    XFER_BYTE = 1'b0,
    XFER_BIT  = 1'b1
  } xfer_mode_e;

  function automatic xfer_mode_e mode_of(input logic sel);
    return sel ? XFER_BIT : XFER_BYTE;
  endfunction
endpackage

// File: rtl/csp_queue.sv
module csp_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          has_data,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign head     = slots[rd_ptr];
  assign has_data = (fill != '0);
  assign full     = (fill == CW'(DEPTH));
endmodule

// File: rtl/csp_unit_sel.sv
module csp_unit_sel
  import coded_serial_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  xfer_mode_e   mode,
  input  logic         q_has,
  input  logic [W-1:0] q_head,
  input  logic         take,
  output logic         q_pop,
  output logic         avail,
  output logic [W-1:0] unit
);
  localparam int BW = $clog2(W + 1);

  logic [W-1:0]  shreg;
  logic [BW-1:0] bits_left;
  logic          mid_byte;
  logic          cur_bit;

  assign mid_byte = (bits_left != '0);
  assign avail    = q_has | ((mode == XFER_BIT) & mid_byte);
  assign q_pop    = take & ((mode == XFER_BYTE) | !mid_byte);
  assign cur_bit  = mid_byte ? shreg[W-1] : q_head[W-1];

  always_comb begin
    if (mode == XFER_BIT) unit = {{(W-1){1'b0}}, cur_bit};
    else                  unit = q_head;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      bits_left <= '0;
    end else if (take && mode == XFER_BIT) begin
      if (mid_byte) begin
        shreg     <= shreg << 1;
        bits_left <= bits_left - BW'(1);
      end else begin
        shreg     <= q_head << 1;
        bits_left <= BW'(W - 1);
      end
    end
  end
endmodule

// File: rtl/csp_pin_stage.sv
module csp_pin_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         avail,
  input  logic [W-1:0] unit,
  output logic [W-1:0] dout,
  output logic         dout_oe
);
  logic took_q;
  logic oe_next;

  assign oe_next = take | (dout_oe & (avail | took_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_oe <= 1'b0;
      took_q  <= 1'b0;
    end else begin
      took_q  <= take;
      dout_oe <= oe_next;
      if (take)                   dout <= unit;
      else if (dout_oe && !oe_next) dout <= '0;
    end
  end
endmodule

// File: rtl/coded_serial_port.sv
module coded_serial_port
  import coded_serial_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_mode,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         rd_en_n,
  output logic         nonempty,
  output logic [W-1:0] dout,
  output logic         dout_oe
);
  xfer_mode_e   mode;
  logic         q_full, q_has, q_pop, push, take, avail;
  logic [W-1:0] q_head, unit;

  assign mode     = mode_of(bit_mode);
  assign in_ready = !q_full;
  assign push     = in_valid & in_ready;
  assign take     = !rd_en_n & avail;
  assign nonempty = avail;

  csp_queue #(.W(W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(in_data),
    .pop(q_pop), .head(q_head), .has_data(q_has), .full(q_full)
  );

  csp_unit_sel #(.W(W)) u_sel (
    .clk(clk), .rst_n(rst_n), .mode(mode), .q_has(q_has), .q_head(q_head),
    .take(take), .q_pop(q_pop), .avail(avail), .unit(unit)
  );

  csp_pin_stage #(.W(W)) u_pins (
    .clk(clk), .rst_n(rst_n), .take(take), .avail(avail), .unit(unit),
    .dout(dout), .dout_oe(dout_oe)
  );
endmodule

// File: rtl/coded_serial_port_chk.sv
module coded_serial_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bit_mode,
  input logic         in_ready,
  input logic         rd_en_n,
  input logic         nonempty,
  input logic [W-1:0] dout,
  input logic         dout_oe
);
  // R2: a full queue always has something to send
  p_full_has_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> nonempty);

  // R4: a read with data waiting drives the pins on the next cycle
  p_read_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_n && nonempty) |=> dout_oe);

  // R9: a paused edge leaves the data unchanged
  p_pause_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_n && nonempty && dout_oe) |=> ($stable(dout) && dout_oe));

  // R8: the tail lasts one cycle after the last item
  p_tail_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!nonempty && dout_oe && $past(!nonempty) && $past(dout_oe)) |=> !dout_oe);

  // R6: in bit mode only the lowest pin carries data
  p_bit_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_mode && $past(bit_mode)) |-> (dout[W-1:1] == '0));
endmodule

bind coded_serial_port coded_serial_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_mode(bit_mode), .in_ready(in_ready),
  .rd_en_n(rd_en_n), .nonempty(nonempty), .dout(dout), .dout_oe(dout_oe)
);

// File: tb/sim_coded_serial_port.sv
`timescale 1ns/1ps
module sim_coded_serial_port;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_mode = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       rd_en_n = 1'b1;
  logic       in_ready, nonempty, dout_oe;
  logic [7:0] dout;

  always #2.5 clk = ~clk;

  coded_serial_port #(.W(8), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_mode(bit_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .rd_en_n(rd_en_n),
    .nonempty(nonempty), .dout(dout), .dout_oe(dout_oe)
  );

  int    tests = 0;
  int    fails = 0;
  int    cyc   = 0;
  string phase = "R1";

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference: byte queue, bit store, drive/tail tracking
  logic [7:0] mq[$];
  logic [7:0] m_sh = '0;
  int         m_bits = 0;
  logic [7:0] m_dout = '0;
  logic       m_oe = 1'b0;
  int         m_idle = 0;

  function automatic logic m_avail();
    return (mq.size() > 0) || (bit_mode && m_bits > 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_sh = '0; m_bits = 0; m_dout = '0; m_oe = 1'b0; m_idle = 0;
    end else begin
      automatic logic avl  = m_avail();
      automatic logic popx = !rd_en_n && avl;
      automatic logic pshx = in_valid && (mq.size() < DEPTH);
      if (popx) begin
        if (!bit_mode) m_dout = mq.pop_front();
        else if (m_bits > 0) begin
          m_dout = {7'b0, m_sh[7]}; m_sh = m_sh << 1; m_bits--;
        end else begin
          automatic logic [7:0] b = mq.pop_front();
          m_dout = {7'b0, b[7]}; m_sh = b << 1; m_bits = 7;
        end
        m_oe = 1'b1; m_idle = 0;
      end else if (m_oe && !avl) begin
        m_idle++;
        if (m_idle >= 2) begin m_oe = 1'b0; m_dout = '0; end
      end
      if (pshx) mq.push_back(in_data);
    end
  end

  // compare every cycle, 1 ns after the edge
  always @(posedge clk) begin
    cyc++;
    #1;
    if (rst_n) begin
      chk("R7", nonempty, m_avail());
      chk("R8", dout_oe, m_oe);
      chk("R2", in_ready, mq.size() < DEPTH);
      chk(phase, dout, m_dout);
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic push_n(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = base + 8'(i * 17);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (nonempty || dout_oe) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk("R1", {nonempty, dout_oe, in_ready}, 3'b001);
    chk("R1", dout, 8'h00);

    // R3: one byte sets nonempty
    phase = "R3";
    push_n(1, 8'hA5);
    chk("R3", nonempty, 1'b1);
    // R4: first read presents the byte
    phase = "R4";
    rd_en_n = 1'b0;
    @(negedge clk);
    chk("R4", {dout_oe, dout}, {1'b1, 8'hA5});
    repeat (4) @(negedge clk);
    rd_en_n = 1'b1;

    // R5/R7/R8: continuous byte stream
    phase = "R5";
    push_n(5, 8'h10);
    rd_en_n = 1'b0;
    wait_idle();
    rd_en_n = 1'b1;

    // R2: fill past capacity, in_valid held
    phase = "R2";
    @(negedge clk); in_valid = 1'b1; in_data = 8'h30;
    for (int i = 0; i < DEPTH + 3; i++) begin
      @(negedge clk);
      if (in_ready) in_data = in_data + 8'd3;
    end
    chk("R2", in_ready, 1'b0);
    in_valid = 1'b0;

    // R9: duty-cycled read drains full queue
    phase = "R9";
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); rd_en_n = (i % 3 == 2);
    end
    rd_en_n = 1'b1;
    wait_idle();

    // R6/R10: bit mode, two bytes back to back
    bit_mode = 1'b1;
    phase = "R6";
    push_n(2, 8'hC3);
    rd_en_n = 1'b0;
    @(negedge clk);
    chk("R6", dout, 8'h01);
    phase = "R10";
    wait_idle();
    rd_en_n = 1'b1;

    // R9: pause in the middle of a byte
    phase = "R9";
    push_n(2, 8'h5A);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); rd_en_n = (i >= 4 && i < 7) || (i == 12);
    end
    rd_en_n = 1'b0;
    wait_idle();

    // R11: read held low over empty port
    phase = "R11";
    repeat (6) @(negedge clk);
    chk("R11", {nonempty, dout_oe}, 2'b00);
    rd_en_n = 1'b1;

    // R10: writes during a byte-mode stream
    bit_mode = 1'b0;
    phase = "R10";
    @(negedge clk); rd_en_n = 1'b0;
    fork
      push_n(6, 8'h71);
    join
    wait_idle();
    rd_en_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule